// File: doc/BRIEF.md
# Suspend Handshake Controller

This block decides when the processor core may sit in a low-power suspend state. It answers an active-low suspend request with an active-low acknowledge. The request is only honoured while a configuration enable is set. The acknowledge waits until outstanding core work and any bus-master transfer have drained. Release of the acknowledge is held back while a memory refresh is running. While the core is suspended, a bus-master request breaks the suspend so the transfer can be served. Once the transfer finishes, the block returns to suspend on its own if the request is still present.

Interrupt and SMI events that arrive during a suspend episode are each remembered once, as sticky flags. A consumer clears a flag with a one-cycle pulse after the core is awake again. The request input is asynchronous and passes through a two-flop synchronizer. All other inputs are synchronous to the clock.

Top module: `slphs_top`

## Requirements
- R1: While `sleepEn` is low, a low `sleepReqN` never causes `sleepAckN` to go low.
- R2: After reset, `sleepAckN` is 1 and `intrPend` and `smiPend` are 0.
- R3: With `coreBusy`, `pciReq` and `pciActive` all low, `sleepAckN` goes low on the fourth rising edge after `sleepReqN` falls (two synchronizer stages plus two state steps), and not earlier.
- R4: While `coreBusy` is high, `sleepAckN` does not go low. It goes low on the first rising edge at which `coreBusy` is sampled low.
- R5: While `pciReq` or `pciActive` is high, `sleepAckN` does not go low. If the request arrives during a transfer, the acknowledge follows one edge after the transfer ends.
- R6: With `refreshActive` low, `sleepAckN` returns to 1 on the third rising edge after `sleepReqN` rises, which is one edge after the synchronized sample shows the request inactive.
- R7: While `refreshActive` is high and `pciReq` is low, an asserted `sleepAckN` stays low. It rises on the first edge at which `refreshActive` is sampled low.
- R8: During a suspend episode (acknowledged, serving a bus master, or waiting out a refresh), an `intrIn` pulse sets `intrPend`. Further pulses change nothing. Outside an episode, `intrIn` is ignored.
- R9: `smiIn` sets `smiPend` under the same rules as R8, and this includes pulses that arrive while a bus-master transfer is being served.
- R10: While suspended, a high `pciReq` drives `sleepAckN` to 1 on the next rising edge.
- R11: When `pciReq` and `pciActive` are both low again, `sleepAckN` returns low on the next edge if the request is still held and enabled and `coreBusy` is low. Otherwise it stays 1.
- R12: A one-cycle `intrClr`/`smiClr` pulse clears its flag only when no suspend episode is in progress. During an episode the pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepReqN | input | 1 | Active-low suspend request, asynchronous |
| sleepEn | input | 1 | Configuration enable for suspend requests |
| coreBusy | input | 1 | Core still has instructions or bus cycles in flight |
| refreshActive | input | 1 | Memory refresh cycle in progress |
| pciReq | input | 1 | Unmasked bus-master request |
| pciActive | input | 1 | Bus-master transfer in progress |
| intrIn | input | 1 | Interrupt event pulse |
| smiIn | input | 1 | SMI event pulse |
| intrClr | input | 1 | Consumer clear pulse for the interrupt flag |
| smiClr | input | 1 | Consumer clear pulse for the SMI flag |
| sleepAckN | output | 1 | Active-low suspend acknowledge |
| intrPend | output | 1 | Sticky interrupt-pending flag |
| smiPend | output | 1 | Sticky SMI-pending flag |

## Verification
The properties assume that every input except `sleepReqN` changes only in step with `clk`. They also assume that event and clear pulses last one cycle and are sampled on a single rising edge. The bench meets this by driving all inputs one time unit after a rising edge, and by raising the request only through the same timed path, so the synchronizer sees a clean level. Refresh is held long enough around the exit to exercise the postponement, and the bus-master request is raised only in states where the block must react to it.

// File: rtl/slphs_pkg.sv
package slphs_pkg;
  // One-hot phase encoding of the handshake controller
  typedef enum logic [4:0] {
    PH_IDLE  = 5'b00001,
    PH_DRAIN = 5'b00010,
    PH_SLEEP = 5'b00100,
    PH_PCI   = 5'b01000,
    PH_EXIT  = 5'b10000
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capEn;  // suspend episode in progress: capture events
    logic clrEn;  // core awake: accept clear pulses
  } dpCtl_t;

  localparam int DEF_SYNC_STAGES = 2;
  localparam int EVT_COUNT       = 2;
endpackage

// File: rtl/slphs_dp.sv
module slphs_dp
  import slphs_pkg::*;
#(
  parameter int SYNC_STAGES = DEF_SYNC_STAGES,
  parameter int NUM_EVT     = EVT_COUNT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqInN,
  input  dpCtl_t             ctl,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic [NUM_EVT-1:0] evtClr,
  output logic               reqOn,
  output logic [NUM_EVT-1:0] evtPend
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;

  // Request synchronizer; resets to the inactive (high) level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[LAST-1:0], reqInN};
  end

  assign reqOn = ~syncQ[LAST];

  // One sticky latch per event kind
  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                        evtPend[g] <= 1'b0;
      else if (ctl.capEn && evtIn[g])   evtPend[g] <= 1'b1;
      else if (ctl.clrEn && evtClr[g])  evtPend[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/slphs_ctrl.sv
module slphs_ctrl
  import slphs_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqOn,
  input  logic   sleepEn,
  input  logic   coreBusy,
  input  logic   refreshActive,
  input  logic   pciReq,
  input  logic   pciActive,
  output dpCtl_t ctl,
  output logic   ackN
);
  phase_e phase, phaseNext;
  logic   reqEff, pciDone;

  assign reqEff  = reqOn & sleepEn;
  assign pciDone = ~pciReq & ~pciActive;

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE:  if (reqEff) phaseNext = PH_DRAIN;
      PH_DRAIN: begin
        if (!reqEff)                    phaseNext = PH_IDLE;
        else if (!coreBusy && pciDone)  phaseNext = PH_SLEEP;
      end
      PH_SLEEP: begin
        if (pciReq)                     phaseNext = PH_PCI;
        else if (!reqEff)               phaseNext = refreshActive ? PH_EXIT : PH_IDLE;
      end
      PH_PCI: begin
        if (pciDone) begin
          if (!reqEff)                  phaseNext = PH_IDLE;
          else if (coreBusy)            phaseNext = PH_DRAIN;
          else                          phaseNext = PH_SLEEP;
        end
      end
      PH_EXIT:  if (!refreshActive) phaseNext = PH_IDLE;
      default:  phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  assign ackN      = ~((phase == PH_SLEEP) | (phase == PH_EXIT));
  assign ctl.capEn = (phase == PH_SLEEP) | (phase == PH_PCI) | (phase == PH_EXIT);
  assign ctl.clrEn = (phase == PH_IDLE) | (phase == PH_DRAIN);
endmodule

// File: rtl/slphs_top.sv
module slphs_top
  import slphs_pkg::*;
#(
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rstN,
  input  logic sleepReqN,
  input  logic sleepEn,
  input  logic coreBusy,
  input  logic refreshActive,
  input  logic pciReq,
  input  logic pciActive,
  input  logic intrIn,
  input  logic smiIn,
  input  logic intrClr,
  input  logic smiClr,
  output logic sleepAckN,
  output logic intrPend,
  output logic smiPend
);
  dpCtl_t                 ctl;
  logic                   reqOn;
  logic [EVT_COUNT-1:0]   evtPend;

  slphs_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqOn(reqOn), .sleepEn(sleepEn),
    .coreBusy(coreBusy), .refreshActive(refreshActive),
    .pciReq(pciReq), .pciActive(pciActive),
    .ctl(ctl), .ackN(sleepAckN)
  );

  slphs_dp #(.SYNC_STAGES(SYNC_STAGES), .NUM_EVT(EVT_COUNT)) dp_i (
    .clk(clk), .rstN(rstN), .reqInN(sleepReqN), .ctl(ctl),
    .evtIn({smiIn, intrIn}), .evtClr({smiClr, intrClr}),
    .reqOn(reqOn), .evtPend(evtPend)
  );

  assign intrPend = evtPend[0];
  assign smiPend  = evtPend[1];
endmodule

// File: rtl/slphs_chk.sv
module slphs_chk (
  input logic clk,
  input logic rstN,
  input logic sleepEn,
  input logic coreBusy,
  input logic refreshActive,
  input logic pciReq,
  input logic pciActive,
  input logic intrClr,
  input logic sleepAckN,
  input logic intrPend
);
  // R1: disabled requests never produce an acknowledge
  a_r1_no_ack_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!sleepEn && sleepAckN) |=> sleepAckN);

  // R4: in-flight core work holds the acknowledge off
  a_r4_busy_holds_off: assert property (@(posedge clk) disable iff (!rstN)
    (coreBusy && sleepAckN) |=> sleepAckN);

  // R5: bus-master activity holds the acknowledge off
  a_r5_pci_holds_off: assert property (@(posedge clk) disable iff (!rstN)
    ((pciReq || pciActive) && sleepAckN) |=> sleepAckN);

  // R7: refresh keeps an asserted acknowledge in place
  a_r7_refresh_keeps_ack: assert property (@(posedge clk) disable iff (!rstN)
    (!sleepAckN && refreshActive && !pciReq) |=> !sleepAckN);

  // R8: pending interrupt flag is sticky until a clear pulse
  a_r8_intr_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (intrPend && !intrClr) |=> intrPend);

  // R12: a clear pulse during an acknowledged suspend is ignored
  a_r12_clear_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (intrPend && intrClr && !sleepAckN) |=> intrPend);
endmodule

bind slphs_top slphs_chk chk_i (
  .clk(clk), .rstN(rstN), .sleepEn(sleepEn), .coreBusy(coreBusy),
  .refreshActive(refreshActive), .pciReq(pciReq), .pciActive(pciActive),
  .intrClr(intrClr), .sleepAckN(sleepAckN), .intrPend(intrPend)
);

// File: tb/slphs_top_tb_top.sv
module slphs_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sleepReqN = 1'b1, sleepEn = 1'b0, coreBusy = 1'b0, refreshActive = 1'b0;
  logic pciReq = 1'b0, pciActive = 1'b0, intrIn = 1'b0, smiIn = 1'b0;
  logic intrClr = 1'b0, smiClr = 1'b0;
  logic sleepAckN, intrPend, smiPend;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  typedef struct {
    logic  ack;
    logic  ip;
    logic  sp;
    string tag;
  } exp_t;

  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  slphs_top dut_i (
    .clk(clk), .rstN(rstN), .sleepReqN(sleepReqN), .sleepEn(sleepEn),
    .coreBusy(coreBusy), .refreshActive(refreshActive), .pciReq(pciReq),
    .pciActive(pciActive), .intrIn(intrIn), .smiIn(smiIn),
    .intrClr(intrClr), .smiClr(smiClr), .sleepAckN(sleepAckN),
    .intrPend(intrPend), .smiPend(smiPend)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expectNow(input logic ack, input logic ip, input logic sp, input string tag);
    exp_t e;
    e.ack = ack; e.ip = ip; e.sp = sp; e.tag = tag;
    expQ.push_back(e);
  endtask

  // Monitor: compares queued expectations at the falling edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      compared++;
      if (sleepAckN !== e.ack || intrPend !== e.ip || smiPend !== e.sp) begin
        mismatched++;
        $display("FAIL %s: ack/intr/smi got %b%b%b expected %b%b%b",
                 e.tag, sleepAckN, intrPend, smiPend, e.ack, e.ip, e.sp);
      end
    end
  end

  task automatic pulseIntr();
    intrIn = 1'b1; tick(1); intrIn = 1'b0;
  endtask

  task automatic pulseSmi();
    smiIn = 1'b1; tick(1); smiIn = 1'b0;
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    expectNow(1, 0, 0, "R2 reset state");

    // R1: request with enable low
    sleepReqN = 1'b0;
    tick(8);
    expectNow(1, 0, 0, "R1 disabled request ignored");
    pulseIntr();
    expectNow(1, 0, 0, "R8 interrupt outside suspend ignored");
    sleepReqN = 1'b1;
    tick(4);
    sleepEn = 1'b1;

    // R3: entry latency
    sleepReqN = 1'b0;
    tick(3);
    expectNow(1, 0, 0, "R3 no ack before fourth edge");
    tick(1);
    expectNow(0, 0, 0, "R3 ack on fourth edge");

    // R8 / R12 inside suspend
    pulseIntr();
    expectNow(0, 1, 0, "R8 interrupt captured");
    pulseIntr();
    expectNow(0, 1, 0, "R8 second interrupt no change");
    intrClr = 1'b1; tick(1); intrClr = 1'b0;
    expectNow(0, 1, 0, "R12 clear ignored while suspended");

    // R10 / R11 bus-master break and return
    pciReq = 1'b1;
    tick(1);
    expectNow(1, 1, 0, "R10 pci request breaks suspend");
    pulseSmi();
    expectNow(1, 1, 1, "R9 smi captured during pci service");
    pciActive = 1'b1; pciReq = 1'b0;
    tick(2);
    expectNow(1, 1, 1, "R11 stays awake while transfer active");
    pciActive = 1'b0;
    tick(1);
    expectNow(0, 1, 1, "R11 ack returns after transfer");

    // R7 refresh postpones exit
    refreshActive = 1'b1;
    sleepReqN = 1'b1;
    tick(5);
    expectNow(0, 1, 1, "R7 ack held during refresh");
    refreshActive = 1'b0;
    tick(1);
    expectNow(1, 1, 1, "R7 ack released after refresh");

    // R12 clears accepted once awake
    intrClr = 1'b1; tick(1); intrClr = 1'b0;
    expectNow(1, 0, 1, "R12 interrupt flag cleared");
    smiClr = 1'b1; tick(1); smiClr = 1'b0;
    expectNow(1, 0, 0, "R12 smi flag cleared");

    // R4 busy holds off
    coreBusy = 1'b1;
    sleepReqN = 1'b0;
    tick(7);
    expectNow(1, 0, 0, "R4 busy holds off ack");
    coreBusy = 1'b0;
    tick(1);
    expectNow(0, 0, 0, "R4 ack after busy clears");

    // R6 exit latency without refresh
    sleepReqN = 1'b1;
    tick(2);
    expectNow(0, 0, 0, "R6 ack still low on second edge");
    tick(1);
    expectNow(1, 0, 0, "R6 ack released on third edge");

    // R5 request during transfer
    pciActive = 1'b1;
    sleepReqN = 1'b0;
    tick(7);
    expectNow(1, 0, 0, "R5 transfer holds off ack");
    pciActive = 1'b0;
    tick(1);
    expectNow(0, 0, 0, "R5 ack after transfer ends");

    // R11 transfer ends after request withdrawn
    pciReq = 1'b1;
    tick(1);
    expectNow(1, 0, 0, "R10 pci request breaks suspend again");
    sleepReqN = 1'b1;
    tick(3);
    pciReq = 1'b0;
    tick(1);
    expectNow(1, 0, 0, "R11 no return without request");
    tick(3);
    expectNow(1, 0, 0, "R11 stays awake");

    tick(2);
    done = 1'b1;
  end

  // Watchdog and end of run
  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not finish, got cycle %0d expected under %0d", cyc, WATCHDOG);
    end
    @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule